// File: doc/BRIEF.md
# Inbound Write Interrupt Message Forwarder

This block sits between a downstream I/O port and an upstream system-bus port. Every inbound memory write is offered to a small first-in first-out posting buffer. A write that finds free space is posted at once. A write that finds the buffer full is turned away in the same cycle with a retry indication, so the requester tries again later and the block never stalls the downstream side.

The block classifies a write only after it has been posted, and only when that write reaches the head of the buffer. A write whose address lies in the interrupt message window (upper twelve address bits equal to 0xFEE) is sent upstream tagged as an interrupt message, but only if it carries PCI-style semantics. Every other write goes upstream tagged as an ordinary memory write. Interrupt messages use the same admission and retry path as any other write. Because entries leave strictly in arrival order, an interrupt message never overtakes a write posted before it.

Top module: `irq_wr_forwarder`

## Requirements
- R1: While reset is held and in the first cycle after it, `up_valid` is 0, and `in_accept` and `in_retry` are 0 when `in_valid` is 0.
- R2: When `in_valid` is 1 and fewer than DEPTH (default 4) writes are held, `in_accept` is 1 and `in_retry` is 0 in that same cycle, and the write is posted at the next clock edge. When `in_valid` is 0, both are 0.
- R3: When `in_valid` is 1 and DEPTH writes are held, `in_retry` is 1 and `in_accept` is 0 in that same cycle, even if an upstream transfer completes in that cycle. The rejected write is not stored.
- R4: A posted write with `in_pci_sem` = 1 whose address bits [31:20] equal 0xFEE (0xFEE00000 to 0xFEEFFFFF) leaves with `up_kind` = 1 (interrupt message).
- R5: A write outside that window, or with `in_pci_sem` = 0 (including one inside the window), leaves with `up_kind` = 0 (memory write).
- R6: Writes leave upstream in exactly the order they were accepted.
- R7: While `up_valid` is 1 and `up_ready` is 0, `up_valid`, `up_kind`, `up_addr` and `up_data` hold their values into the next cycle.
- R8: A write accepted into an empty buffer raises `up_valid` in the cycle after the accepting edge and not before. `up_valid` is 1 exactly when at least one write is held.
- R9: `up_addr` and `up_data` equal the address and data of the write as it was accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Downstream write request present this cycle |
| in_addr | input | 32 | Write address |
| in_data | input | 32 | Write data |
| in_pci_sem | input | 1 | 1 when the write carries PCI-style semantics |
| in_accept | output | 1 | Write posted this cycle (combinational) |
| in_retry | output | 1 | Write rejected, requester must retry (combinational) |
| up_valid | output | 1 | Upstream transaction available |
| up_ready | input | 1 | Upstream port takes the transaction this cycle |
| up_kind | output | 1 | 1 = interrupt message, 0 = memory write |
| up_addr | output | 32 | Transaction address |
| up_data | output | 32 | Transaction data |

## Verification
A bad occupancy count shows up at the ports in the first cycle the count matters. It either gives a retry while the bench's own count still shows room, or it accepts a write that must be rejected. The accepted write then appears as an extra or missing transaction when the buffer drains. A pointer that is off by one, or a slot that is overwritten, gives wrong address, data or order at the next upstream transfer. A wrong classification gives a tag mismatch on that same transfer. The checks also catch an output that changes while the upstream side stalls, in the very next cycle, and a one-cycle latency error on the first write into an empty buffer.

// File: rtl/irqfwd_pkg.sv
// Package: shared widths, the posted-entry record and the upstream
// transaction tag used throughout the forwarder.
package irqfwd_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    // One posted inbound write as stored in the buffer.
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              pci_sem;
    } wr_entry_t;

    // Tag carried with each upstream transaction.
    typedef enum logic {
        XACT_MEMWR  = 1'b0,
        XACT_INTMSG = 1'b1
    } xact_kind_t;
endpackage

// File: rtl/irqfwd_admit.sv
// Admission control: decides in the request cycle whether an inbound
// write is posted or rejected. Assumes `full` reflects registered state
// only (no bypass from a same-cycle upstream transfer).
module irqfwd_admit (
    input  logic in_valid,
    input  logic full,
    output logic accept,
    output logic retry
);
    // Accept when there is room, otherwise ask for a retry.
    always_comb begin
        accept = in_valid && !full;
        retry  = in_valid &&  full;
    end
endmodule

// File: rtl/irqfwd_buffer.sv
// Posting buffer: DEPTH-entry FIFO of wr_entry_t. Each slot is a separate
// register bank written when the write pointer selects it. Assumes the
// caller never pushes when full; guards are kept internally regardless.
module irqfwd_buffer
    import irqfwd_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  wr_entry_t push_entry,
    input  logic      pop,
    output wr_entry_t head_entry,
    output logic      empty,
    output logic      full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    wr_entry_t        slot [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push;
    logic             do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    // Qualify the requests with the current occupancy.
    always_comb begin
        empty   = (count == '0);
        full    = (count == CNT_FULL);
        do_push = push && !full;
        do_pop  = pop && !empty;
    end

    // One register bank per slot, loaded when selected by the write pointer.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot[i] <= '0;
            else if (do_push && (wr_ptr == PTR_W'(i)))
                slot[i] <= push_entry;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Present the oldest entry.
    always_comb head_entry = slot[rd_ptr];
endmodule

// File: rtl/irqfwd_decode.sv
// Post-buffer classifier: tags the head entry as an interrupt message when
// its address lies in the window and it carries PCI-style semantics.
module irqfwd_decode
    import irqfwd_pkg::*;
#(
    parameter int                 WIN_TAG_W = 12,
    parameter logic [WIN_TAG_W-1:0] WIN_TAG = 12'hFEE
) (
    input  wr_entry_t  entry,
    output xact_kind_t kind
);
    logic in_window;

    // Window match on the upper address bits, then semantics qualification.
    always_comb begin
        in_window = (entry.addr[ADDR_W-1 -: WIN_TAG_W] == WIN_TAG);
        kind      = (in_window && entry.pci_sem) ? XACT_INTMSG : XACT_MEMWR;
    end
endmodule

// File: rtl/irq_wr_forwarder.sv
// Top: inbound write posting with retry, in-order drain and interrupt
// message tagging. Assumes the upstream side obeys valid/ready: it may
// stall, and outputs are held while it does.
module irq_wr_forwarder
    import irqfwd_pkg::*;
#(
    parameter int                   DEPTH     = 4,
    parameter int                   WIN_TAG_W = 12,
    parameter logic [WIN_TAG_W-1:0] WIN_TAG   = 12'hFEE
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] in_addr,
    input  logic [31:0] in_data,
    input  logic        in_pci_sem,
    output logic        in_accept,
    output logic        in_retry,
    output logic        up_valid,
    input  logic        up_ready,
    output logic        up_kind,
    output logic [31:0] up_addr,
    output logic [31:0] up_data
);
    wr_entry_t  new_entry;
    wr_entry_t  head;
    xact_kind_t head_kind;
    logic       buf_empty;
    logic       buf_full;

    // Pack the inbound request into a buffer record.
    always_comb begin
        new_entry.addr    = in_addr;
        new_entry.data    = in_data;
        new_entry.pci_sem = in_pci_sem;
    end

    irqfwd_admit u_admit (
        .in_valid (in_valid),
        .full     (buf_full),
        .accept   (in_accept),
        .retry    (in_retry)
    );

    irqfwd_buffer #(.DEPTH(DEPTH)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (in_accept),
        .push_entry (new_entry),
        .pop        (up_valid && up_ready),
        .head_entry (head),
        .empty      (buf_empty),
        .full       (buf_full)
    );

    irqfwd_decode #(.WIN_TAG_W(WIN_TAG_W), .WIN_TAG(WIN_TAG)) u_dec (
        .entry (head),
        .kind  (head_kind)
    );

    // Drive the upstream port from the head entry.
    always_comb begin
        up_valid = !buf_empty;
        up_kind  = head_kind;
        up_addr  = head.addr;
        up_data  = head.data;
    end
endmodule

// File: rtl/irqfwd_checker.sv
// Checker: tracks occupancy from port handshakes and checks admission,
// hold and tagging rules. Attached to the top by bind.
module irqfwd_checker #(
    parameter int DEPTH = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_accept,
    input logic        in_retry,
    input logic        up_valid,
    input logic        up_ready,
    input logic        up_kind,
    input logic [31:0] up_addr,
    input logic [31:0] up_data
);
    localparam int OCC_W = $clog2(DEPTH + 1) + 1;
    logic [OCC_W-1:0] occ;

    // Occupancy as seen from the handshakes at the ports.
    always_ff @(posedge clk) begin
        if (!rst_n)
            occ <= '0;
        else
            occ <= occ + OCC_W'(in_accept) - OCC_W'(up_valid && up_ready);
    end

    assert_accept_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && occ < OCC_W'(DEPTH)) |-> (in_accept && !in_retry));

    assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (!in_accept && !in_retry));

    assert_retry_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && occ == OCC_W'(DEPTH)) |-> (in_retry && !in_accept));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_W'(DEPTH));

    assert_intmsg_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_kind) |-> (up_addr[31:20] == 12'hFEE));

    assert_hold_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_ready) |=>
        (up_valid && $stable(up_addr) && $stable(up_data) && $stable(up_kind)));

    assert_valid_occ_R8: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid == (occ != '0));
endmodule

bind irq_wr_forwarder irqfwd_checker #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_accept (in_accept),
    .in_retry  (in_retry),
    .up_valid  (up_valid),
    .up_ready  (up_ready),
    .up_kind   (up_kind),
    .up_addr   (up_addr),
    .up_data   (up_data)
);

// File: tb/irq_wr_forwarder_test.sv
// Scoreboard bench: the driver pushes expected transactions, the monitor
// pops and compares them as the upstream port hands them over.
module irq_wr_forwarder_test;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic [31:0] in_data = '0;
    logic        in_pci_sem = 1'b0;
    logic        in_accept, in_retry;
    logic        up_valid;
    logic        up_ready = 1'b0;
    logic        up_kind;
    logic [31:0] up_addr, up_data;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit reported = 1'b0;
    logic [64:0] sb [$];   // {kind, addr, data}

    always #4 clk = ~clk;   // 125 MHz

    irq_wr_forwarder #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .in_data(in_data), .in_pci_sem(in_pci_sem), .in_accept(in_accept),
        .in_retry(in_retry), .up_valid(up_valid), .up_ready(up_ready),
        .up_kind(up_kind), .up_addr(up_addr), .up_data(up_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [64:0] act, input logic [64:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        end
    endtask

    // Offer one write; acceptance is predicted from the bench's own count.
    task automatic send(input logic [31:0] a, input logic [31:0] d,
                        input logic s, input logic rdy);
        logic exp_acc;
        logic kind;
        @(negedge clk);
        up_ready   = rdy;
        in_valid   = 1'b1;
        in_addr    = a;
        in_data    = d;
        in_pci_sem = s;
        #1;
        exp_acc = (sb.size() < DEPTH);
        if (exp_acc)
            check(in_accept && !in_retry, "R2", "accept with room",
                  {in_accept, in_retry}, 2'b10);
        else
            check(in_retry && !in_accept, "R3", "retry when full",
                  {in_accept, in_retry}, 2'b01);
        if (exp_acc) begin
            kind = s && (a[31:20] == 12'hFEE);   // R4 / R5 rule
            sb.push_back({kind, a, d});
        end
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic idle(input logic rdy);
        @(negedge clk);
        up_ready = rdy;
    endtask

    // Monitor: compares each handshake against the scoreboard and checks hold.
    logic        prev_stall = 1'b0;
    logic [64:0] prev_out = '0;
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n) begin
                if (prev_stall)
                    check(up_valid && {up_kind, up_addr, up_data} == prev_out,
                          "R7", "hold during stall",
                          {up_kind, up_addr, up_data}, prev_out);
                if (up_valid && up_ready) begin
                    if (sb.size() == 0)
                        check(1'b0, "R6", "unexpected transaction",
                              {up_kind, up_addr, up_data}, '0);
                    else begin
                        logic [64:0] e;
                        e = sb.pop_front();
                        check({up_kind, up_addr, up_data} == e,
                              "R6/R9/R4/R5", "order, payload and tag",
                              {up_kind, up_addr, up_data}, e);
                    end
                end
                prev_stall = up_valid && !up_ready;
                prev_out   = {up_kind, up_addr, up_data};
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            report();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check(!up_valid && !in_accept && !in_retry, "R1", "outputs in reset",
              {up_valid, in_accept, in_retry}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(!up_valid && !in_accept && !in_retry, "R1", "outputs after reset",
              {up_valid, in_accept, in_retry}, '0);

        // R8: first write into empty buffer, upstream stalled
        @(negedge clk);
        #1;
        check(!up_valid, "R8", "empty before post", up_valid, 0);
        send(32'hFEE0_1000, 32'h0000_0041, 1'b1, 1'b0);
        check(up_valid, "R8", "valid one cycle after post", up_valid, 1);

        // Window boundaries and semantics (R4, R5), drained in order (R6)
        send(32'hFEE0_0000, 32'h1111_0001, 1'b1, 1'b0);
        send(32'hFEEF_FFFF, 32'h1111_0002, 1'b1, 1'b0);
        send(32'hFEE4_0000, 32'h1111_0003, 1'b0, 1'b0);
        // Buffer now holds 4: retries (R3), also with a same-cycle pop
        send(32'h1000_0000, 32'hDEAD_0001, 1'b1, 1'b0);
        send(32'h2000_0000, 32'hDEAD_0002, 1'b1, 1'b1);
        send(32'hFEDF_FFFC, 32'h2222_0001, 1'b1, 1'b1);
        send(32'hFEF0_0000, 32'h2222_0002, 1'b1, 1'b1);
        send(32'h0000_0010, 32'h2222_0003, 1'b0, 1'b1);
        repeat (8) idle(1'b1);
        check(!up_valid && sb.size() == 0, "R3", "rejected writes never emerge",
              {up_valid, 32'(sb.size())}, '0);

        // Mixed stream with random stalls
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            logic        r;
            r = ($urandom_range(0, 3) != 0);
            a = $urandom();
            if ($urandom_range(0, 2) == 0) a[31:20] = 12'hFEE;
            if ($urandom_range(0, 4) == 0) idle(r);
            else send(a, $urandom(), 1'($urandom_range(0, 1)), r);
        end
        for (int i = 0; i < 20; i++) idle(1'b1);
        @(negedge clk);
        #3;
        check(!up_valid && sb.size() == 0, "R6", "stream fully drained",
              {up_valid, 32'(sb.size())}, '0);

        done = 1'b1;
        report();
        $finish;
    end
endmodule